// File: doc/BRIEF.md
# Audio Sample FIFO with Request Watermarks

This block buffers 32-bit audio subframes on the transmit side of a display output. A DMA engine pushes words through a dedicated write port. The audio serialiser takes one word on each sample tick. The fill level drives two request outputs. The DMA request keeps the engine topped up. The panic request raises bus priority when the buffer runs low. Each output has its own low/high threshold pair and follows a hysteresis rule.

Software reaches the block through a small register port with two words. The control word holds enable, channel count, flush and a one-shot reset. It also reports empty and full, plus three sticky error flags: overflow, underflow and data-late. Each error flag is cleared by writing 1 to it. The threshold word holds the four 6-bit watermarks.

Two small state machines shape the behaviour. The run machine has two states, `RUN_OFF` and `RUN_ON`:
- It moves to `RUN_ON` on a plain control write with the enable bit set.
- It returns to `RUN_OFF` on a plain control write with enable clear, or on a reset command.

Each watermark machine has two states, `WM_QUIET` and `WM_CALL`:
- It moves to `WM_CALL` when the level is at or below its low mark.
- It moves back to `WM_QUIET` when the level is at or above its high mark.

Top module: `audio_sample_fifo`

## Requirements
- R1: Out of reset, the control word (address 0) reads 0x00000400, with only the empty bit (bit 10) set. The threshold word (address 1) reads 0x10101010. `smp_valid` is low.
- R2: A clock edge is counted as a pop when `smp_tick` is sampled high on it, the enable bit (control bit 3) is set and the FIFO is not empty. On the cycle after each pop, `smp_valid` is high and `smp_data` holds the oldest stored word. Words leave in the order they were written.
- R3: A DMA write while 32 words are stored is dropped, leaving the contents unchanged. It sets the sticky overflow flag (control bit 1).
- R4: A tick sampled while enabled with the FIFO empty sets both the underflow flag (control bit 2) and the data-late flag (control bit 15). It produces no `smp_valid`.
- R5: Writing 1 to bit 1, 2 or 15 of the control word clears that flag, and writing 0 leaves it unchanged. When a set event and a clear fall on the same edge, the set wins.
- R6: While the enable bit is clear, ticks have no effect: no pop, no `smp_valid`, no flag change.
- R7: A control write with flush (bit 9) set and reset (bit 0) clear empties the FIFO. It applies the write-one-to-clear bits and leaves enable and channel count unchanged. Any DMA write or tick on the same edge is discarded.
- R8: A control write with bit 0 set empties the FIFO, clears all three flags, clears enable and channel count, and discards a same-edge DMA write or tick. The threshold word is unaffected.
- R9: The control word reports empty in bit 10 and full in bit 11, following the current fill level. Bits 0 and 9 always read 0.
- R10: `dma_req` rises one cycle after an edge where the level is at or below the DMA-low field (threshold bits 5:0). It falls one cycle after an edge where the level is at or above the DMA-high field (bits 13:8).
- R11: `panic_req` follows the same rule as R10 with the panic-low field (bits 21:16) and the panic-high field (bits 29:24).
- R12: A write to the threshold word stores only bits 5:0, 13:8, 21:16 and 29:24. All other bits read back as 0.
- R13: `chan_cnt` and control bits 7:4 show the channel count from the last plain control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 thresholds) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| dma_we | input | 1 | DMA word write strobe |
| dma_wdata | input | 32 | DMA word |
| dma_req | output | 1 | DMA request with hysteresis |
| panic_req | output | 1 | Panic request with hysteresis |
| smp_tick | input | 1 | Sample-due pulse from the consumer |
| smp_valid | output | 1 | Popped word present this cycle |
| smp_data | output | 32 | Popped subframe |
| chan_cnt | output | 4 | Programmed channel count |

## Verification
The assertions take for granted three things about the inputs:
- The register port and the DMA port are synchronous to `clk`.
- A tick is a single-cycle level, sampled once per edge.
- The threshold inputs may change at any time, because each watermark check compares the level and threshold that were present on the same past edge.

The stimulus stays within these limits by driving every input on the falling edge. It issues reset and flush commands only through the control word, so a command can land on the same edge as a DMA write or a tick. That covers the discard rules in R7 and R8.

// File: rtl/afs_pkg.sv
package afs_pkg;
    // Control word bit positions (software decodes these).
    localparam int CTL_RST    = 0;
    localparam int CTL_OVF    = 1;
    localparam int CTL_UNF    = 2;
    localparam int CTL_EN     = 3;
    localparam int CTL_CH_LSB = 4;
    localparam int CTL_CH_W   = 4;
    localparam int CTL_FLUSH  = 9;
    localparam int CTL_EMPTY  = 10;
    localparam int CTL_FULL   = 11;
    localparam int CTL_LATE   = 15;

    // Threshold word layout.
    localparam int TH_W   = 6;
    localparam int TH_DLO = 0;
    localparam int TH_DHI = 8;
    localparam int TH_PLO = 16;
    localparam int TH_PHI = 24;
    localparam logic [31:0] TH_RESET = 32'h1010_1010;
    localparam logic [31:0] TH_MASK  = 32'h3F3F_3F3F;

    typedef enum logic {WM_QUIET, WM_CALL} wm_state_e;
    typedef enum logic {RUN_OFF, RUN_ON} run_state_e;
endpackage

// File: rtl/afs_store.sv
module afs_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            level <= level + LW'(push) - LW'(pop);
        end
    end

    assign head = mem[rd_ptr];

    // R3
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear) |=> level == $past(level) + 1'b1);
    // R7
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> level == '0);
endmodule

// File: rtl/afs_wmark.sv
module afs_wmark
    import afs_pkg::*;
#(
    parameter int LW = 6,
    localparam int CW = (LW > TH_W) ? LW : TH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   level,
    input  logic [TH_W-1:0] lo,
    input  logic [TH_W-1:0] hi,
    output logic            req
);
    wm_state_e state, nxt;
    logic [CW-1:0] lvl_c, lo_c, hi_c;

    assign lvl_c = CW'(level);
    assign lo_c  = CW'(lo);
    assign hi_c  = CW'(hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WM_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WM_QUIET: if (lvl_c <= lo_c) nxt = WM_CALL;
            WM_CALL:  if (lvl_c >= hi_c) nxt = WM_QUIET;
        endcase
    end

    always_comb req = (state == WM_CALL);

    // R10
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> CW'($past(level)) <= CW'($past(lo)));
    // R11
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> CW'($past(level)) >= CW'($past(hi)));
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import afs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int RAW   = 2,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           dma_we,
    input  logic [DW-1:0]  dma_wdata,
    output logic           dma_req,
    output logic           panic_req,
    input  logic           smp_tick,
    output logic           smp_valid,
    output logic [DW-1:0]  smp_data,
    output logic [3:0]     chan_cnt
);
    localparam logic [RAW-1:0] A_CTL = RAW'(0);
    localparam logic [RAW-1:0] A_THR = RAW'(1);

    run_state_e run_q, run_d;
    logic [31:0] thr_q;
    logic [CTL_CH_W-1:0] ch_q;
    logic ovf_q, unf_q, late_q;
    logic [LW-1:0] level;
    logic [DW-1:0] head;
    logic [1:0] req_v;

    logic ctl_wr, thr_wr, rst_cmd, flush_cmd, clr, plain_wr;
    logic en, full, empty;
    logic push_ok, pop_ok, starve, ovf_hit, idle_tick;

    assign ctl_wr    = reg_we && (reg_addr == A_CTL);
    assign thr_wr    = reg_we && (reg_addr == A_THR);
    assign rst_cmd   = ctl_wr && reg_wdata[CTL_RST];
    assign flush_cmd = ctl_wr && reg_wdata[CTL_FLUSH] && !reg_wdata[CTL_RST];
    assign clr       = rst_cmd || flush_cmd;
    assign plain_wr  = ctl_wr && !reg_wdata[CTL_RST] && !reg_wdata[CTL_FLUSH];

    assign en        = (run_q == RUN_ON);
    assign full      = (level == LW'(DEPTH));
    assign empty     = (level == '0);
    assign push_ok   = dma_we && !full && !clr;
    assign ovf_hit   = dma_we && full && !clr;
    assign pop_ok    = smp_tick && en && !clr && !empty;
    assign starve    = smp_tick && en && !clr && empty;
    assign idle_tick = smp_tick && !en && !clr;

    // Run state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RUN_OFF;
        else        run_q <= run_d;
    end

    // Run state machine: transitions
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_OFF: if (plain_wr && reg_wdata[CTL_EN]) run_d = RUN_ON;
            RUN_ON:  if (rst_cmd || (plain_wr && !reg_wdata[CTL_EN])) run_d = RUN_OFF;
        endcase
    end

    // Control fields and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            late_q <= 1'b0;
            thr_q  <= TH_RESET;
        end else begin
            if (thr_wr) thr_q <= reg_wdata & TH_MASK;
            if (rst_cmd) begin
                ch_q   <= '0;
                ovf_q  <= 1'b0;
                unf_q  <= 1'b0;
                late_q <= 1'b0;
            end else begin
                if (plain_wr) ch_q <= reg_wdata[CTL_CH_LSB +: CTL_CH_W];
                ovf_q  <= (ovf_q  && !(ctl_wr && reg_wdata[CTL_OVF]))  || ovf_hit;
                unf_q  <= (unf_q  && !(ctl_wr && reg_wdata[CTL_UNF]))  || starve;
                late_q <= (late_q && !(ctl_wr && reg_wdata[CTL_LATE])) || starve;
            end
        end
    end

    // Sample output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= pop_ok;
            if (pop_ok) smp_data <= head;
        end
    end

    afs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .push  (push_ok),
        .wdata (dma_wdata),
        .pop   (pop_ok),
        .head  (head),
        .level (level)
    );

    // Watermark pair 0 drives the DMA request, pair 1 the panic request.
    for (genvar g = 0; g < 2; g++) begin : g_wm
        localparam int LO_POS = (g == 0) ? TH_DLO : TH_PLO;
        localparam int HI_POS = (g == 0) ? TH_DHI : TH_PHI;
        afs_wmark #(.LW(LW)) u_wm (
            .clk   (clk),
            .rst_n (rst_n),
            .level (level),
            .lo    (thr_q[LO_POS +: TH_W]),
            .hi    (thr_q[HI_POS +: TH_W]),
            .req   (req_v[g])
        );
    end

    // Outputs
    always_comb begin
        dma_req   = req_v[0];
        panic_req = req_v[1];
        chan_cnt  = ch_q;
        reg_rdata = '0;
        if (reg_addr == A_CTL) begin
            reg_rdata[CTL_OVF]   = ovf_q;
            reg_rdata[CTL_UNF]   = unf_q;
            reg_rdata[CTL_EN]    = en;
            reg_rdata[CTL_CH_LSB +: CTL_CH_W] = ch_q;
            reg_rdata[CTL_EMPTY] = empty;
            reg_rdata[CTL_FULL]  = full;
            reg_rdata[CTL_LATE]  = late_q;
        end else if (reg_addr == A_THR) begin
            reg_rdata = thr_q;
        end
    end

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> ovf_q);
    // R4
    starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> (unf_q && late_q && !smp_valid));
    // R6
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_tick && !dma_we) |=> (!smp_valid && level == $past(level)));
    // R8
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (!en && level == '0 && !ovf_q && !unf_q && !late_q));
    // R2
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(level) != '0);
endmodule

// File: tb/tb_audio_sample_fifo.sv
`timescale 1ns/1ps
module tb_audio_sample_fifo;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_we = 1'b0;
    logic [31:0] dma_wdata = '0;
    logic        dma_req, panic_req;
    logic        smp_tick = 1'b0;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic [3:0]  chan_cnt;

    always #5 clk = ~clk;

    audio_sample_fifo dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_we(dma_we), .dma_wdata(dma_wdata),
        .dma_req(dma_req), .panic_req(panic_req),
        .smp_tick(smp_tick), .smp_valid(smp_valid), .smp_data(smp_data),
        .chan_cnt(chan_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] q[$];
    bit m_ovf, m_unf, m_late, m_en, m_sv, m_dreq, m_panic;
    logic [3:0]  m_ch;
    logic [31:0] m_thr = 32'h1010_1010;
    logic [31:0] m_sd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit wm_next(input bit st, input int lvl, input int lo, input int hi);
        if (!st) return (lvl <= lo);
        return !(lvl >= hi);
    endfunction

    task automatic check_all();
        reg_addr = 2'd0;
        #1;
        chk("R3 overflow flag", 32'(reg_rdata[1]), 32'(m_ovf));
        chk("R4 underflow flag", 32'(reg_rdata[2]), 32'(m_unf));
        chk("R4 late flag", 32'(reg_rdata[15]), 32'(m_late));
        chk("R7 enable", 32'(reg_rdata[3]), 32'(m_en));
        chk("R13 channel field", 32'(reg_rdata[7:4]), 32'(m_ch));
        chk("R9 empty", 32'(reg_rdata[10]), 32'(q.size() == 0));
        chk("R9 full", 32'(reg_rdata[11]), 32'(q.size() == DEPTH));
        chk("R9 zero bits", 32'({reg_rdata[31:16], reg_rdata[14:12], reg_rdata[9:8], reg_rdata[0]}), 32'd0);
        reg_addr = 2'd1;
        #1;
        chk("R12 thresholds", reg_rdata, m_thr);
        chk("R10 dma_req", 32'(dma_req), 32'(m_dreq));
        chk("R11 panic_req", 32'(panic_req), 32'(m_panic));
        chk("R2 smp_valid", 32'(smp_valid), 32'(m_sv));
        if (m_sv) chk("R2 smp_data", smp_data, m_sd);
        chk("R13 chan_cnt", 32'(chan_cnt), 32'(m_ch));
    endtask

    task automatic step(input bit we, input logic [31:0] wd, input bit tick,
                        input bit rwe, input logic [1:0] ra, input logic [31:0] rwd);
        bit ctl_wr, rst_cmd, fl_cmd, clr, pop_try;
        int lvl;
        dma_we = we; dma_wdata = wd; smp_tick = tick;
        reg_we = rwe; reg_addr = ra; reg_wdata = rwd;
        @(posedge clk);
        lvl     = q.size();
        ctl_wr  = rwe && ra == 2'd0;
        rst_cmd = ctl_wr && rwd[0];
        fl_cmd  = ctl_wr && rwd[9] && !rwd[0];
        clr     = rst_cmd || fl_cmd;
        pop_try = tick && m_en && !clr;
        m_dreq  = wm_next(m_dreq,  lvl, int'(m_thr[5:0]),   int'(m_thr[13:8]));
        m_panic = wm_next(m_panic, lvl, int'(m_thr[21:16]), int'(m_thr[29:24]));
        m_sv = pop_try && lvl > 0;
        if (m_sv) m_sd = q[0];
        if (rst_cmd) begin
            m_ovf = 0; m_unf = 0; m_late = 0; m_en = 0; m_ch = '0;
        end else begin
            if (ctl_wr && rwd[1])  m_ovf = 0;
            if (ctl_wr && rwd[2])  m_unf = 0;
            if (ctl_wr && rwd[15]) m_late = 0;
            if (we && lvl == DEPTH && !clr) m_ovf = 1;
            if (pop_try && lvl == 0) begin m_unf = 1; m_late = 1; end
            if (ctl_wr && !fl_cmd) begin m_en = rwd[3]; m_ch = rwd[7:4]; end
        end
        if (rwe && ra == 2'd1) m_thr = rwd & 32'h3F3F_3F3F;
        if (clr) q.delete();
        else begin
            if (m_sv) void'(q.pop_front());
            if (we && lvl < DEPTH) q.push_back(wd);
        end
        @(negedge clk);
        dma_we = 0; smp_tick = 0; reg_we = 0;
        check_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic wctl(input logic [31:0] v);
        step(0, 0, 0, 1, 2'd0, v);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_A0D1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_addr = 2'd0; #1;
        chk("R1 ctrl reset", reg_rdata, 32'h0000_0400);
        reg_addr = 2'd1; #1;
        chk("R1 thr reset", reg_rdata, 32'h1010_1010);
        chk("R1 smp_valid reset", 32'(smp_valid), 32'd0);
        check_all();

        // Enable, two channels, fill to full, then overflow (R3)
        wctl(32'h0000_0028);
        for (int i = 0; i < DEPTH; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, 0);
        step(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
        reg_addr = 2'd0; #1;
        chk("R3 overflow after full write", 32'(reg_rdata[1]), 32'd1);
        // R5 clear overflow by writing 1 (enable kept by same plain write)
        wctl(32'h0000_002A);
        // Drain in order (R2), then starve (R4)
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        reg_addr = 2'd0; #1;
        chk("R4 late after dry tick", 32'(reg_rdata[15]), 32'd1);
        // R5 set beats clear on the same edge
        step(0, 0, 1, 1, 2'd0, 32'h0000_8026);
        // R5 write zero leaves flags
        wctl(32'h0000_0028);
        wctl(32'h0000_8006 | 32'h28);
        // R6 disabled ticks ignored
        wctl(32'h0000_0020);
        for (int i = 0; i < 3; i++) step(1, 32'h5500_0000 + i, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0);
        reg_addr = 2'd0; #1;
        chk("R6 level kept while disabled", 32'(reg_rdata[10]), 32'd0);
        // R7 flush keeps enable
        wctl(32'h0000_0038);
        step(1, 32'h1, 1, 1, 2'd0, 32'h0000_0200);
        reg_addr = 2'd0; #1;
        chk("R7 enable after flush", 32'(reg_rdata[3]), 32'd1);
        chk("R7 empty after flush", 32'(reg_rdata[10]), 32'd1);
        // R8 reset command
        for (int i = 0; i < 5; i++) step(1, 32'h7700_0000 + i, 0, 0, 0, 0);
        step(1, 32'h2, 1, 1, 2'd0, 32'h0000_0039);
        reg_addr = 2'd0; #1;
        chk("R8 ctrl after reset cmd", reg_rdata, 32'h0000_0400);
        // R12 threshold masking; R10/R11 with distinct pairs
        step(0, 0, 0, 1, 2'd1, 32'hFF14_FF12);
        reg_addr = 2'd1; #1;
        chk("R12 masked thresholds", reg_rdata, 32'h3F14_3F12);
        step(0, 0, 0, 1, 2'd1, 32'h0804_0C06);
        wctl(32'h0000_0088);
        for (int i = 0; i < 14; i++) step(1, 32'hC000_0000 + i, 0, 0, 0, 0);
        for (int i = 0; i < 14; i++) step(0, 0, 1, 0, 0, 0);
        idle(2);

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            bit we, tk, rwe;
            logic [1:0] ra;
            logic [31:0] rwd;
            we  = ($urandom % 100) < 50;
            tk  = ($urandom % 100) < 42;
            rwe = ($urandom % 100) < 4;
            ra  = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
            rwd = $urandom;
            if (ra == 2'd0) begin
                rwd[0] = ($urandom % 16) == 0;
                rwd[9] = ($urandom % 8) == 0;
                rwd[3] = ($urandom % 4) != 0;
            end else begin
                rwd[5:0]   = 6'($urandom % 20);
                rwd[13:8]  = 6'(rwd[5:0] + ($urandom % 12));
                rwd[21:16] = 6'($urandom % 12);
                rwd[29:24] = 6'(rwd[21:16] + ($urandom % 12));
            end
            step(we, $urandom, tk, rwe, ra, rwd);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule